// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block sits beside a small 8-bit controller core and decides which of five interrupt sources the core services next. The sources are two external request lines, two timer overflow flags, and a serial-port request. The serial request is raised when either the receive-complete flag or the transmit-complete flag is set. Software writes an enable register and a priority register. Each source is placed at a low or a high level, and one global bit gates the whole block.

Time is divided into machine cycles of six clock states. Request flags are captured once per machine cycle, in one fixed state, and the captured set is judged in the first state of the next machine cycle. The high level is considered first. Within a level, a fixed polling order picks the winner. The winner is granted unless a routine of equal or higher level is already running, or the core holds the block off. A grant produces a one-clock acknowledge with the call target, and marks that level as in progress. A return strobe from the core retires the highest level in progress. An external source in edge mode also gets a one-clock clear pulse with its grant.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable register and the priority register read 0, ack is 0, and both in-progress flags are 0.
- R2: A write with cfg_sel=0 loads the enable register and a write with cfg_sel=1 loads the priority register. The enable register keeps bit 7 (global) and bits 4..0. The priority register keeps bits 4..0. All other bits read 0. Source bit positions are ext0=0, tmr0=1, ext1=2, tmr1=3, serial=4.
- R3: The acknowledged vector is 0x0003 + 8 × source index, which gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023 for source indices 0 to 4.
- R4: Nothing is acknowledged while the global enable bit (bit 7) is 0, or while the source's own enable bit is 0.
- R5: Request inputs are captured only in clock state 4 of the six-state machine cycle (states counted 0..5 from reset). A request present at that capture is acknowledged in the clock after the next state-0 edge. A request pulse that misses state 4 is never seen.
- R6: A pending high-level request (priority bit 1) beats any low-level request. Within one level, the lowest source index wins.
- R7: A high-level request preempts a running low-level routine. A low-level request waits while a low-level routine runs. No request is granted while a high-level routine runs.
- R8: A return strobe clears the high in-progress flag if it is set, and otherwise clears the low flag. With neither flag set, it changes nothing.
- R9: The serial source is pending when ser_rx_done or ser_tx_done is 1.
- R10: When external source j is granted with ext_edge_mode[j]=1, ext_clr[j] is 1 in the ack cycle. In level mode, ext_clr stays 0.
- R11: While core_hold is 1 at the decision edge, no grant is made. The request is granted at a later decision after core_hold falls.
- R12: ack lasts exactly one clock per grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects enable register, 1 selects priority register |
| cfg_wdata | input | 8 | Write data |
| ext_req | input | 2 | External request flags (bit 0 ext0, bit 1 ext1) |
| ext_edge_mode | input | 2 | 1 marks the external flag as edge type |
| tmr_ovf | input | 2 | Timer overflow flags (bit 0 tmr0, bit 1 tmr1) |
| ser_rx_done | input | 1 | Serial receive-complete flag |
| ser_tx_done | input | 1 | Serial transmit-complete flag |
| core_hold | input | 1 | Core cannot take a call now |
| reti_strobe | input | 1 | Return-from-interrupt strobe |
| ack | output | 1 | One-clock grant pulse |
| ack_vec | output | 16 | Call target, valid with ack |
| ext_clr | output | 2 | Clear pulse for edge-mode external flags |
| en_reg | output | 8 | Enable register contents |
| pri_reg | output | 8 | Priority register contents |
| busy_hi | output | 1 | High-level routine in progress |
| busy_lo | output | 1 | Low-level routine in progress |

## Verification
A request held across a state-4 edge is captured at that edge. The decision is registered at the following state-0 edge, two edges later, so ack, ack_vec and ext_clr are visible only when the count of edges since reset is 1 modulo 6. The monitor rejects an ack at any other count. The in-progress flags change on the ack edge itself, and a return strobe takes effect one edge after it is driven. The bench therefore holds each stimulus for three full machine cycles before judging whether an expected grant arrived. It also removes requests two machine cycles before a return, so that no stale captured request is granted again.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned SRC_N = 5;
   localparam int unsigned IDX_W = 3;

   // polling order equals index order
   typedef enum logic [IDX_W-1:0] {
      SRC_EXT0 = 3'd0,
      SRC_TMR0 = 3'd1,
      SRC_EXT1 = 3'd2,
      SRC_TMR1 = 3'd3,
      SRC_SER  = 3'd4
   } src_e;

   typedef struct packed {
      logic             found;
      logic             lvl_hi;
      logic [IDX_W-1:0] idx;
   } pick_t;
endpackage

// File: rtl/irqc_phase.sv
module irqc_phase #(
   parameter int unsigned PHASES    = 6,
   parameter int unsigned SAMPLE_AT = 4,
   parameter int unsigned EVAL_AT   = 0
) (
   input  logic clk,
   input  logic rst_n,
   output logic sample_o,
   output logic eval_o
);
   localparam int unsigned PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;
   localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

   logic [PH_W-1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             ph_q <= '0;
      else if (ph_q == LAST_PH) ph_q <= '0;
      else                    ph_q <= ph_q + 1'b1;
   end

   assign sample_o = (ph_q == PH_W'(SAMPLE_AT));
   assign eval_o   = (ph_q == PH_W'(EVAL_AT));
endmodule

// File: rtl/irqc_first.sv
module irqc_first #(
   parameter int unsigned N     = 5,
   parameter int unsigned IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   logic [N:0]   seen;
   logic [N-1:0] first;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign seen[i+1] = seen[i] | req[i];
      assign first[i]  = req[i] & ~seen[i];
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (first[i]) idx = idx | IDX_W'(i);
      end
   end

   assign found = seen[N];
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
   import irqc_pkg::*;
#(
   parameter int unsigned N = SRC_N
) (
   input  logic [N-1:0] pend_hi,
   input  logic [N-1:0] pend_lo,
   output pick_t        pick_o
);
   logic             hi_found, lo_found;
   logic [IDX_W-1:0] hi_idx, lo_idx;

   irqc_first #(.N(N), .IDX_W(IDX_W)) u_hi (.req(pend_hi), .found(hi_found), .idx(hi_idx));
   irqc_first #(.N(N), .IDX_W(IDX_W)) u_lo (.req(pend_lo), .found(lo_found), .idx(lo_idx));

   always_comb begin
      pick_o.found  = hi_found | lo_found;
      pick_o.lvl_hi = hi_found;
      pick_o.idx    = hi_found ? hi_idx : lo_idx;
   end
endmodule

// File: rtl/irqc_nest.sv
module irqc_nest (
   input  logic clk,
   input  logic rst_n,
   input  logic reti_i,
   input  logic grant_i,
   input  logic grant_hi_i,
   output logic busy_hi_o,
   output logic busy_lo_o
);
   logic hi_q, lo_q, hi_d, lo_d;

   always_comb begin
      hi_d = hi_q;
      lo_d = lo_q;
      if (reti_i) begin
         if (hi_q) hi_d = 1'b0;
         else      lo_d = 1'b0;
      end
      if (grant_i) begin
         if (grant_hi_i) hi_d = 1'b1;
         else            lo_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= 1'b0;
         lo_q <= 1'b0;
      end else begin
         hi_q <= hi_d;
         lo_q <= lo_d;
      end
   end

   assign busy_hi_o = hi_q;
   assign busy_lo_o = lo_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned PHASES     = 6,
   parameter int unsigned SAMPLE_AT  = 4,
   parameter int unsigned EVAL_AT    = 0,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned GE_BIT     = 7,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8,
   parameter int unsigned EXT_N      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic [EXT_N-1:0]  ext_req,
   input  logic [EXT_N-1:0]  ext_edge_mode,
   input  logic [1:0]        tmr_ovf,
   input  logic              ser_rx_done,
   input  logic              ser_tx_done,
   input  logic              core_hold,
   input  logic              reti_strobe,
   output logic              ack,
   output logic [ADDR_W-1:0] ack_vec,
   output logic [EXT_N-1:0]  ext_clr,
   output logic [DATA_W-1:0] en_reg,
   output logic [DATA_W-1:0] pri_reg,
   output logic              busy_hi,
   output logic              busy_lo
);
   localparam logic [DATA_W-1:0] SRC_MASK = DATA_W'((1 << SRC_N) - 1);
   localparam logic [DATA_W-1:0] EN_MASK  = SRC_MASK | (DATA_W'(1) << GE_BIT);
   localparam logic [ADDR_W-1:0] BASE_V   = ADDR_W'(VEC_BASE);
   localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(VEC_STRIDE);

   initial begin
      assert (SAMPLE_AT < PHASES && EVAL_AT < PHASES) else $error("phase index out of range");
      assert (SAMPLE_AT != EVAL_AT) else $error("capture and decision share a state");
      assert (GE_BIT < DATA_W && GE_BIT >= SRC_N) else $error("global enable bit misplaced");
      assert (EXT_N == 2) else $error("source map fixes two external lines");
      assert (VEC_BASE + (SRC_N - 1) * VEC_STRIDE < (1 << ADDR_W)) else $error("vector overflows address");
   end

   // ---------------- software registers ----------------
   logic [DATA_W-1:0] en_q, pri_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         pri_q <= '0;
      end else if (cfg_we) begin
         if (cfg_sel) pri_q <= cfg_wdata & SRC_MASK;
         else         en_q  <= cfg_wdata & EN_MASK;
      end
   end

   // ---------------- capture ----------------
   logic sample_stb, eval_stb;

   irqc_phase #(.PHASES(PHASES), .SAMPLE_AT(SAMPLE_AT), .EVAL_AT(EVAL_AT)) u_phase (
      .clk(clk), .rst_n(rst_n), .sample_o(sample_stb), .eval_o(eval_stb)
   );

   logic [SRC_N-1:0] raw_req, snap_q;

   assign raw_req = {ser_rx_done | ser_tx_done, tmr_ovf[1], ext_req[1], tmr_ovf[0], ext_req[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          snap_q <= '0;
      else if (sample_stb) snap_q <= raw_req;
   end

   // ---------------- arbitration ----------------
   logic [SRC_N-1:0] en_src, pend, pend_hi, pend_lo;
   pick_t            pick;
   logic             allowed, grant;

   assign en_src  = en_q[SRC_N-1:0] & {SRC_N{en_q[GE_BIT]}};
   assign pend    = snap_q & en_src;
   assign pend_hi = pend & pri_q[SRC_N-1:0];
   assign pend_lo = pend & ~pri_q[SRC_N-1:0];

   irqc_pick #(.N(SRC_N)) u_pick (.pend_hi(pend_hi), .pend_lo(pend_lo), .pick_o(pick));

   always_comb begin
      if (!pick.found)      allowed = 1'b0;
      else if (pick.lvl_hi) allowed = !busy_hi;
      else                  allowed = !busy_hi && !busy_lo;
   end

   assign grant = eval_stb && !core_hold && allowed;

   irqc_nest u_nest (
      .clk(clk), .rst_n(rst_n), .reti_i(reti_strobe),
      .grant_i(grant), .grant_hi_i(pick.lvl_hi),
      .busy_hi_o(busy_hi), .busy_lo_o(busy_lo)
   );

   // ---------------- outputs ----------------
   logic [EXT_N-1:0]  clr_d, clr_q;
   logic [ADDR_W-1:0] vec_d, vec_q;
   logic              ack_q;

   for (genvar j = 0; j < EXT_N; j++) begin : g_ext_clr
      localparam logic [IDX_W-1:0] EXT_IDX = IDX_W'(2 * j);
      assign clr_d[j] = grant && (pick.idx == EXT_IDX) && ext_edge_mode[j];
   end

   assign vec_d = BASE_V + ADDR_W'(pick.idx) * STRIDE_V;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         vec_q <= '0;
         clr_q <= '0;
      end else begin
         ack_q <= grant;
         vec_q <= grant ? vec_d : '0;
         clr_q <= clr_d;
      end
   end

   assign ack     = ack_q;
   assign ack_vec = vec_q;
   assign ext_clr = clr_q;
   assign en_reg  = en_q;
   assign pri_reg = pri_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned GE_BIT     = 7,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              core_hold,
   input logic              reti_strobe,
   input logic              ack,
   input logic [ADDR_W-1:0] ack_vec,
   input logic [DATA_W-1:0] en_reg,
   input logic              busy_hi,
   input logic              busy_lo
);
   localparam logic [ADDR_W-1:0] BASE_V   = ADDR_W'(VEC_BASE);
   localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(VEC_STRIDE);
   localparam logic [ADDR_W-1:0] TOP_V    = ADDR_W'(VEC_BASE + 4 * VEC_STRIDE);

   p_vec_grid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (ack_vec >= BASE_V && ack_vec <= TOP_V && ((ack_vec - BASE_V) % STRIDE_V) == '0));

   p_needs_global_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(en_reg[GE_BIT]));

   p_ack_sets_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (busy_hi || busy_lo));

   p_hi_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_hi && !reti_strobe) |=> busy_hi);

   p_reti_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_strobe && !busy_hi && busy_lo) |=> !busy_lo);

   p_hold_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> !$past(core_hold));

   p_one_clock_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);
endmodule

bind prio_irq_ctrl irqc_chk #(
   .DATA_W(DATA_W), .GE_BIT(GE_BIT), .ADDR_W(ADDR_W),
   .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .core_hold(core_hold), .reti_strobe(reti_strobe),
   .ack(ack), .ack_vec(ack_vec), .en_reg(en_reg),
   .busy_hi(busy_hi), .busy_lo(busy_lo)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [1:0]  ext_req = '0, ext_edge_mode = '0, tmr_ovf = '0;
   logic        ser_rx_done = 1'b0, ser_tx_done = 1'b0;
   logic        core_hold = 1'b0, reti_strobe = 1'b0;
   logic        ack;
   logic [15:0] ack_vec;
   logic [1:0]  ext_clr;
   logic [7:0]  en_reg, pri_reg;
   logic        busy_hi, busy_lo;

   always #2.5 clk = ~clk;

   prio_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .ext_req(ext_req), .ext_edge_mode(ext_edge_mode), .tmr_ovf(tmr_ovf),
      .ser_rx_done(ser_rx_done), .ser_tx_done(ser_tx_done),
      .core_hold(core_hold), .reti_strobe(reti_strobe),
      .ack(ack), .ack_vec(ack_vec), .ext_clr(ext_clr),
      .en_reg(en_reg), .pri_reg(pri_reg), .busy_hi(busy_hi), .busy_lo(busy_lo)
   );

   int n_cmp = 0, n_bad = 0;
   int edge_n = 0;
   bit done = 0;
   logic [17:0] exp_q[$];
   string       tag_q[$];
   logic        ack_prev = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) edge_n <= 0;
      else        edge_n <= edge_n + 1;
   end

   // monitor: pops expected grants and compares
   always @(negedge clk) begin
      if (rst_n && ack) begin
         n_cmp++;
         if (ack_prev) begin
            n_bad++;
            $display("FAIL R12 ack held two clocks: actual 1 expected 0");
         end
         n_cmp++;
         if (edge_n % 6 != 1) begin
            n_bad++;
            $display("FAIL R5 ack at edge phase %0d expected 1", edge_n % 6);
         end
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R4/R7/R11 unexpected ack: actual vec=%h clr=%b expected none", ack_vec, ext_clr);
         end else begin
            logic [17:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if ({ext_clr, ack_vec} !== e) begin
               n_bad++;
               $display("FAIL %s: actual clr=%b vec=%h expected clr=%b vec=%h",
                        t, ext_clr, ack_vec, e[17:16], e[15:0]);
            end
         end
      end
      ack_prev <= rst_n && ack;
   end

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_ack(input logic [1:0] clr, input logic [15:0] vec, input string tag);
      exp_q.push_back({clr, vec});
      tag_q.push_back(tag);
   endtask

   task automatic drain(input string tag);
      n_cmp++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL %s: actual no ack expected vec=%h", tag, exp_q[0][15:0]);
         exp_q.delete();
         tag_q.delete();
      end
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
      clks(1);
      cfg_we = 1'b0;
      clks(1);
   endtask

   task automatic reti();
      reti_strobe = 1'b1;
      clks(1);
      reti_strobe = 1'b0;
      clks(1);
   endtask

   task automatic set_src(input int i, input logic v);
      case (i)
         0: ext_req[0] = v;
         1: tmr_ovf[0] = v;
         2: ext_req[1] = v;
         3: tmr_ovf[1] = v;
         default: ser_rx_done = v;
      endcase
   endtask

   task automatic clear_all();
      ext_req = '0; tmr_ovf = '0; ser_rx_done = 1'b0; ser_tx_done = 1'b0;
   endtask

   task automatic finish_case(input string tag);
      clks(18);
      drain(tag);
      clear_all();
      clks(12);
      reti();
      clks(12);
      check({tag, " idle after return"}, {30'd0, busy_hi, busy_lo}, 32'd0);
   endtask

   initial begin
      clks(3);
      rst_n = 1'b1;
      clks(1);
      // R1
      check("R1 enable reg", en_reg, 0);
      check("R1 priority reg", pri_reg, 0);
      check("R1 ack", ack, 0);
      check("R1 busy flags", {busy_hi, busy_lo}, 0);

      // R2
      wr(1'b0, 8'hFF); check("R2 enable mask", en_reg, 32'h9F);
      wr(1'b1, 8'hFF); check("R2 priority mask", pri_reg, 32'h1F);
      check("R2 enable untouched", en_reg, 32'h9F);
      wr(1'b1, 8'h00); check("R2 priority clear", pri_reg, 0);

      // R3 every vector
      for (int i = 0; i < 5; i++) begin
         expect_ack(2'b00, 16'(3 + 8 * i), "R3 vector");
         set_src(i, 1'b1);
         finish_case("R3");
      end

      // R6 low-level polling order
      expect_ack(2'b00, 16'h0013, "R6 ext1 before tmr1/serial");
      ext_req[1] = 1'b1; tmr_ovf[1] = 1'b1; ser_tx_done = 1'b1;
      finish_case("R6 order");

      // R6 + R9 high level wins, serial via receive flag
      wr(1'b1, 8'h10);
      expect_ack(2'b00, 16'h0023, "R6/R9 high serial beats low ext0");
      ext_req[0] = 1'b1; ser_rx_done = 1'b1;
      clks(18);
      check("R6 high busy", {busy_hi, busy_lo}, 32'd2);
      finish_case("R6 level");
      wr(1'b1, 8'h00);

      // R9 transmit flag
      expect_ack(2'b00, 16'h0023, "R9 transmit flag");
      ser_tx_done = 1'b1;
      finish_case("R9");

      // R4 global off, then individual off
      wr(1'b0, 8'h1F);
      ext_req[0] = 1'b1;
      clks(18);
      drain("R4 global");
      check("R4 global no busy", {busy_hi, busy_lo}, 0);
      wr(1'b0, 8'h9E);
      clks(18);
      check("R4 source off no busy", {busy_hi, busy_lo}, 0);
      clear_all();
      wr(1'b0, 8'h9F);
      clks(12);

      // R10 edge and level external
      ext_edge_mode = 2'b01;
      expect_ack(2'b01, 16'h0003, "R10 edge clear");
      ext_req[0] = 1'b1;
      finish_case("R10 edge");
      expect_ack(2'b00, 16'h0013, "R10 level no clear");
      ext_req[1] = 1'b1;
      finish_case("R10 level");
      ext_edge_mode = 2'b00;

      // R11 hold
      core_hold = 1'b1;
      tmr_ovf[0] = 1'b1;
      clks(18);
      drain("R11 held");
      check("R11 held busy", {busy_hi, busy_lo}, 0);
      expect_ack(2'b00, 16'h000B, "R11 after release");
      core_hold = 1'b0;
      finish_case("R11");

      // R7 nesting and R8 returns
      wr(1'b1, 8'h0A);
      expect_ack(2'b00, 16'h0003, "R7 low start");
      ext_req[0] = 1'b1;
      clks(18);
      check("R7 low busy", {busy_hi, busy_lo}, 32'd1);
      expect_ack(2'b00, 16'h001B, "R7 high preempts low");
      tmr_ovf[1] = 1'b1;
      clks(18);
      check("R7 both busy", {busy_hi, busy_lo}, 32'd3);
      ext_req[1] = 1'b1; tmr_ovf[0] = 1'b1;
      clks(18);
      drain("R7 blocked under high");
      clear_all();
      clks(12);
      reti();
      check("R8 high retired first", {busy_hi, busy_lo}, 32'd1);
      reti();
      check("R8 low retired", {busy_hi, busy_lo}, 0);
      reti();
      check("R8 idle return no-op", {busy_hi, busy_lo}, 0);
      wr(1'b1, 8'h00);

      // R7 low waits behind low
      expect_ack(2'b00, 16'h000B, "R7 low start tmr0");
      tmr_ovf[0] = 1'b1;
      clks(18);
      ext_req[0] = 1'b1;
      clks(18);
      drain("R7 low blocked by low");
      clear_all();
      clks(12);
      reti();
      clks(12);

      // R5 capture state
      @(negedge clk);
      while (edge_n % 6 != 0) @(negedge clk);
      ext_req[0] = 1'b1;
      @(negedge clk);
      ext_req[0] = 1'b0;
      clks(18);
      drain("R5 missed capture");
      check("R5 missed no busy", {busy_hi, busy_lo}, 0);
      expect_ack(2'b00, 16'h0003, "R5 pulse at capture state");
      while (edge_n % 6 != 4) @(negedge clk);
      ext_req[0] = 1'b1;
      @(negedge clk);
      ext_req[0] = 1'b0;
      finish_case("R5");

      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         done = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule